// File: doc/BRIEF.md
# UART Line Status and Error Tracking

This block holds the receive and transmit bookkeeping behind the line status register of a 16550-style serial port. Characters arrive already deserialized, each with its own parity, framing and break flags. They are queued in a receive FIFO, or in one holding slot when FIFO mode is off. The block reports data availability, overrun and the error flags of the character at the queue head. On the transmit side it queues CPU writes and hands bytes to a shift stage one at a time. It reports holding-empty and transmitter-empty, and raises a holding-empty interrupt request.

The CPU reads a received byte with `rx_rd_i`, which pops the head. It reads the status byte `lsr_o` with `lsr_rd_i`, which clears the sticky status. The external shift stage takes a byte when `tx_load_o` is high and signals completion on `tx_shift_done_i`. Changing `fifo_en_i` empties both queues.

Top module: `uart_lsr_track`

## Requirements
- R1: After reset `lsr_o` is 0x60: data-ready and all error bits are 0, bits 5 and 6 are 1, and the transmit side is idle.
- R2: `lsr_o[0]` is 1 exactly while at least one received character is stored.
- R3: Received characters leave in arrival order on `rx_data_o`. Capacity is RX_DEPTH (16) in FIFO mode and 1 otherwise.
- R4: A character that completes while the receive store is full sets `lsr_o[1]` and is discarded, leaving the stored characters unchanged. A status read clears `lsr_o[1]`.
- R5: `lsr_o[2]` (parity), `lsr_o[3]` (framing) and `lsr_o[4]` (break) show the flags of the head character. A status read clears them until a different character reaches the head.
- R6: A break character is stored as 0x00 with its break flag. Back-to-back break frames store only one character, until a non-break character arrives.
- R7: `lsr_o[7]` is 1 in FIFO mode while any stored character carries a parity, framing or break flag. It is 0 in non-FIFO mode.
- R8: `lsr_o[5]` is 1 when the transmit holding store is empty and 0 from the write that fills it. Transmit capacity is TX_DEPTH in FIFO mode and 1 otherwise. A write to a full store is dropped.
- R9: `lsr_o[6]` is 1 only when both the transmit holding store and the shift stage are empty.
- R10: While the shift stage is free and a byte is held, `tx_load_o` is high with the oldest byte on `tx_load_data_o`. That byte moves to the shift stage at the next edge, and the stage stays busy until `tx_shift_done_i`.
- R11: `thre_irq_o` equals `thre_ie_i` AND `lsr_o[5]`.
- R12: A change of `fifo_en_i` empties both stores, clears overrun, frees the shift stage and takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | 1 selects FIFO mode |
| rx_valid_i | input | 1 | A received character completes this cycle |
| rx_data_i | input | 8 | Received byte |
| rx_perr_i | input | 1 | Parity error flag of the character |
| rx_ferr_i | input | 1 | Missing stop bit flag of the character |
| rx_brk_i | input | 1 | Line held low for a full frame |
| rx_rd_i | input | 1 | CPU reads and pops the receive head |
| rx_data_o | output | 8 | Receive head byte |
| lsr_rd_i | input | 1 | CPU reads the status byte |
| tx_wr_i | input | 1 | CPU writes a transmit byte |
| tx_data_i | input | 8 | Transmit byte |
| tx_shift_done_i | input | 1 | Shift stage finished its byte |
| tx_load_o | output | 1 | Byte handed to the shift stage at next edge |
| tx_load_data_o | output | 8 | Byte being handed over |
| thre_ie_i | input | 1 | Holding-empty interrupt enable |
| lsr_o | output | 8 | Line status byte |
| thre_irq_o | output | 1 | Holding-empty interrupt request |

## Verification
The assertions assume that `fifo_en_i` does not change in the same cycle as a receive push or a transmit write, since the flush would drop that character. They also assume that `tx_shift_done_i` is raised only while a byte is in the shift stage. The stimulus keeps to both. It switches modes only on idle cycles, and it pulses the done input only after a load has been seen. Each control input is held high for one cycle at a time, so every push, pop and read is a single event.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/lsr_fifo.sv
module lsr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          single_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = single_i ? !empty_o : (cnt_q == FULL_CNT);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign dout_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3: occupancy never exceeds the mode capacity
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  a_r3_single_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_i |-> cnt_q <= CW'(1));
endmodule

// File: rtl/lsr_rx_status.sv
module lsr_rx_status
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fifo_mode_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  input  logic              rd_i,
  input  logic              lsr_rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              dr_o,
  output logic              oe_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              bi_o,
  output logic              err_any_o
);
  rx_entry_t     din, head;
  logic          empty, full, accept, push, pop, ovr;
  logic          brk_hold_q, oe_q, mask_q;
  logic [CW-1:0] cnt, err_cnt_q;
  logic          din_err, head_err;

  // consecutive break frames collapse into one stored character
  assign accept = rx_valid_i && !(rx_brk_i && brk_hold_q);
  assign push   = accept && !full;
  assign ovr    = accept && full;
  assign pop    = rd_i && !empty;

  assign din.data = rx_brk_i ? '0 : rx_data_i;
  assign din.perr = rx_perr_i;
  assign din.ferr = rx_ferr_i;
  assign din.brk  = rx_brk_i;

  lsr_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .single_i(!fifo_mode_i),
    .push_i  (push),
    .din_i   (din),
    .pop_i   (rd_i),
    .dout_o  (head),
    .empty_o (empty),
    .full_o  (full),
    .cnt_o   (cnt)
  );

  assign din_err  = din.perr | din.ferr | din.brk;
  assign head_err = head.perr | head.ferr | head.brk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_hold_q <= 1'b0;
      oe_q       <= 1'b0;
      mask_q     <= 1'b0;
      err_cnt_q  <= '0;
    end else if (flush_i) begin
      brk_hold_q <= 1'b0;
      oe_q       <= 1'b0;
      mask_q     <= 1'b0;
      err_cnt_q  <= '0;
    end else begin
      if (rx_valid_i) brk_hold_q <= rx_brk_i;
      if (ovr) oe_q <= 1'b1;
      else if (lsr_rd_i) oe_q <= 1'b0;
      // head flags hidden after a status read, until the head changes
      if (pop || empty) mask_q <= 1'b0;
      else if (lsr_rd_i) mask_q <= 1'b1;
      case ({push && din_err, pop && head_err})
        2'b10:   err_cnt_q <= err_cnt_q + 1'b1;
        2'b01:   err_cnt_q <= err_cnt_q - 1'b1;
        default: err_cnt_q <= err_cnt_q;
      endcase
    end
  end

  assign rd_data_o = empty ? '0 : head.data;
  assign dr_o      = !empty;
  assign oe_o      = oe_q;
  assign pe_o      = !empty && !mask_q && head.perr;
  assign fe_o      = !empty && !mask_q && head.ferr;
  assign bi_o      = !empty && !mask_q && head.brk;
  assign err_any_o = fifo_mode_i && (err_cnt_q != '0);

  // R4: overrun flagged and stored characters untouched
  a_r4_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr && !flush_i) |=> oe_o);
  a_r4_fifo_intact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr && !rd_i && !flush_i) |=> $stable(cnt));
  // R6: repeated break frame adds nothing
  a_r6_single_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_brk_i && brk_hold_q && !rd_i && !flush_i) |=> $stable(cnt));
  // R7: flagged count bounded by occupancy
  a_r7_err_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_q <= cnt);
endmodule

// File: rtl/lsr_tx_status.sv
module lsr_tx_status
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fifo_mode_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              shift_done_i,
  output logic              load_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              thre_o,
  output logic              temt_o
);
  logic          empty, full, busy_q;
  logic [CW-1:0] cnt;

  assign load_o = !busy_q && !empty && !flush_i;

  lsr_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .single_i(!fifo_mode_i),
    .push_i  (wr_i),
    .din_i   (wr_data_i),
    .pop_i   (load_o),
    .dout_o  (load_data_o),
    .empty_o (empty),
    .full_o  (full),
    .cnt_o   (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           busy_q <= 1'b0;
    else if (flush_i)      busy_q <= 1'b0;
    else if (load_o)       busy_q <= 1'b1;
    else if (shift_done_i) busy_q <= 1'b0;
  end

  assign thre_o = empty;
  assign temt_o = empty && !busy_q;

  // R8: accepted write clears holding-empty at the next edge
  a_r8_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full && !flush_i) |=> !thre_o);
  a_r8_capacity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= (fifo_mode_i ? CW'(DEPTH) : CW'(1)));
  // R10: a load occupies the shift stage
  a_r10_one_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (!load_o && !temt_o));
endmodule

// File: rtl/uart_lsr_track.sv
module uart_lsr_track
  import uart_lsr_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              lsr_rd_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_shift_done_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_load_data_o,
  input  logic              thre_ie_i,
  output logic [7:0]        lsr_o,
  output logic              thre_irq_o
);
  logic fifo_en_q, flush;
  logic dr, oe, pe, fe, bi, err_any, thre, temt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fifo_en_q <= 1'b0;
    else         fifo_en_q <= fifo_en_i;
  end
  assign flush = (fifo_en_i != fifo_en_q);

  lsr_rx_status #(.DEPTH(RX_DEPTH)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .fifo_mode_i(fifo_en_q),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_perr_i  (rx_perr_i),
    .rx_ferr_i  (rx_ferr_i),
    .rx_brk_i   (rx_brk_i),
    .rd_i       (rx_rd_i),
    .lsr_rd_i   (lsr_rd_i),
    .rd_data_o  (rx_data_o),
    .dr_o       (dr),
    .oe_o       (oe),
    .pe_o       (pe),
    .fe_o       (fe),
    .bi_o       (bi),
    .err_any_o  (err_any)
  );

  lsr_tx_status #(.DEPTH(TX_DEPTH)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .fifo_mode_i (fifo_en_q),
    .wr_i        (tx_wr_i),
    .wr_data_i   (tx_data_i),
    .shift_done_i(tx_shift_done_i),
    .load_o      (tx_load_o),
    .load_data_o (tx_load_data_o),
    .thre_o      (thre),
    .temt_o      (temt)
  );

  assign lsr_o      = {err_any, temt, thre, bi, fe, pe, oe, dr};
  assign thre_irq_o = thre_ie_i && thre;

  // R5: error bits only accompany stored data
  a_r5_err_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lsr_o[0] |-> (lsr_o[4:2] == 3'b000 && !lsr_o[7]));
  // R9: transmitter empty implies holding empty
  a_r9_temt_thre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_o[6] |-> lsr_o[5]);
  // R12: mode change leaves both sides empty
  a_r12_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (!lsr_o[0] && !lsr_o[1] && lsr_o[6]));
endmodule

// File: tb/uart_lsr_track_bench.sv
module uart_lsr_track_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en_i = 1'b1;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_perr_i = 1'b0, rx_ferr_i = 1'b0, rx_brk_i = 1'b0;
  logic       rx_rd_i = 1'b0, lsr_rd_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       tx_wr_i = 1'b0, tx_shift_done_i = 1'b0, thre_ie_i = 1'b1;
  logic [7:0] tx_data_i = '0;
  logic       tx_load_o, thre_irq_o;
  logic [7:0] tx_load_data_o, lsr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  uart_lsr_track u_uart_lsr_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_perr_i(rx_perr_i),
    .rx_ferr_i(rx_ferr_i), .rx_brk_i(rx_brk_i), .rx_rd_i(rx_rd_i),
    .rx_data_o(rx_data_o), .lsr_rd_i(lsr_rd_i), .tx_wr_i(tx_wr_i),
    .tx_data_i(tx_data_i), .tx_shift_done_i(tx_shift_done_i),
    .tx_load_o(tx_load_o), .tx_load_data_o(tx_load_data_o),
    .thre_ie_i(thre_ie_i), .lsr_o(lsr_o), .thre_irq_o(thre_irq_o)
  );

  // {data, perr, ferr, brk}
  localparam logic [10:0] VEC [8] = '{
    {8'h41, 3'b000}, {8'h5a, 3'b100}, {8'h00, 3'b001}, {8'h33, 3'b010},
    {8'h7e, 3'b000}, {8'h00, 3'b011}, {8'h12, 3'b110}, {8'hc3, 3'b000}
  };

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rx_char(input logic [7:0] d, input logic p, input logic f, input logic b);
    rx_valid_i = 1'b1; rx_data_i = d; rx_perr_i = p; rx_ferr_i = f; rx_brk_i = b;
    tick();
    rx_valid_i = 1'b0; rx_perr_i = 1'b0; rx_ferr_i = 1'b0; rx_brk_i = 1'b0;
  endtask

  task automatic rx_pop();
    rx_rd_i = 1'b1; tick(); rx_rd_i = 1'b0;
  endtask

  task automatic lsr_read();
    lsr_rd_i = 1'b1; tick(); lsr_rd_i = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] d);
    tx_wr_i = 1'b1; tx_data_i = d; tick(); tx_wr_i = 1'b0;
  endtask

  task automatic tx_done();
    tx_shift_done_i = 1'b1; tick(); tx_shift_done_i = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic any_err;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick(); tick();
    // R1 reset state, R11 irq with enable
    chk("R1 lsr after reset", {8'h0, lsr_o}, 16'h0060);
    chk("R11 irq enabled idle", {15'h0, thre_irq_o}, 16'h1);
    chk("R10 no load idle", {15'h0, tx_load_o}, 16'h0);

    // table: push all, read back head flags in order (R3 R5 R7)
    for (int i = 0; i < 8; i++) rx_char(VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    for (int i = 0; i < 8; i++) begin
      any_err = 1'b0;
      for (int j = i; j < 8; j++) any_err |= (VEC[j][2:0] != 3'b000);
      chk("R3 table data", {8'h0, rx_data_o}, {8'h0, VEC[i][10:3]});
      chk("R5 R7 table lsr", {8'h0, lsr_o},
          {8'h0, any_err, 2'b11, VEC[i][0], VEC[i][1], VEC[i][2], 2'b01});
      rx_pop();
    end
    chk("R2 empty after table", {15'h0, lsr_o[0]}, 16'h0);
    chk("R7 no err left", {15'h0, lsr_o[7]}, 16'h0);

    // R3 R4 fill, overrun, order
    for (int i = 0; i < 16; i++) rx_char(8'(i * 3 + 1), 1'b0, 1'b0, 1'b0);
    chk("R4 no overrun at full", {14'h0, lsr_o[1:0]}, 16'h1);
    rx_char(8'hff, 1'b0, 1'b0, 1'b0);
    chk("R4 overrun set", {15'h0, lsr_o[1]}, 16'h1);
    lsr_read();
    chk("R4 overrun cleared by read", {15'h0, lsr_o[1]}, 16'h0);
    for (int i = 0; i < 16; i++) begin
      chk("R3 R4 fifo order", {8'h0, rx_data_o}, {8'h0, 8'(i * 3 + 1)});
      rx_pop();
    end
    chk("R2 R4 dropped char absent", {15'h0, lsr_o[0]}, 16'h0);

    // R5 status read hides head flags until next head
    rx_char(8'h11, 1'b1, 1'b0, 1'b0);
    rx_char(8'h22, 1'b0, 1'b1, 1'b0);
    chk("R5 parity at head", {13'h0, lsr_o[4:2]}, 16'h1);
    lsr_read();
    chk("R5 cleared by read", {13'h0, lsr_o[4:2]}, 16'h0);
    chk("R7 still flagged", {15'h0, lsr_o[7]}, 16'h1);
    rx_pop();
    chk("R5 new head framing", {13'h0, lsr_o[4:2]}, 16'h2);
    rx_pop();

    // R6 break collapsing
    rx_char(8'h00, 1'b0, 1'b1, 1'b1);
    rx_char(8'h00, 1'b0, 1'b1, 1'b1);
    rx_char(8'h00, 1'b0, 1'b1, 1'b1);
    chk("R6 break stored", {8'h0, rx_data_o}, 16'h0);
    chk("R6 break bit", {15'h0, lsr_o[4]}, 16'h1);
    rx_pop();
    chk("R6 only one break", {15'h0, lsr_o[0]}, 16'h0);
    rx_char(8'h55, 1'b0, 1'b0, 1'b0);
    rx_char(8'h9c, 1'b0, 1'b0, 1'b1);
    rx_pop();
    chk("R6 break after normal char", {7'h0, lsr_o[4], rx_data_o}, 16'h0100);
    rx_pop();
    chk("R2 empty after breaks", {15'h0, lsr_o[0]}, 16'h0);

    // R8 R9 R10 R11 transmit, FIFO mode
    tx_write(8'ha5);
    chk("R8 thre cleared", {14'h0, lsr_o[6:5]}, 16'h0);
    chk("R10 load offered", {7'h0, tx_load_o, tx_load_data_o}, 16'h01a5);
    chk("R11 irq low", {15'h0, thre_irq_o}, 16'h0);
    tick();
    chk("R9 shift busy", {14'h0, lsr_o[6:5]}, 16'h1);
    chk("R11 irq high", {15'h0, thre_irq_o}, 16'h1);
    tx_write(8'hb1);
    tx_write(8'hc2);
    chk("R10 held while busy", {15'h0, tx_load_o}, 16'h0);
    tx_done();
    chk("R10 next byte", {7'h0, tx_load_o, tx_load_data_o}, 16'h01b1);
    tick();
    tx_done();
    chk("R10 third byte", {7'h0, tx_load_o, tx_load_data_o}, 16'h01c2);
    tick();
    chk("R9 busy last", {14'h0, lsr_o[6:5]}, 16'h1);
    tx_done();
    chk("R9 all empty", {14'h0, lsr_o[6:5]}, 16'h3);
    thre_ie_i = 1'b0; #1;
    chk("R11 irq disabled", {15'h0, thre_irq_o}, 16'h0);
    thre_ie_i = 1'b1;

    // R12 mode change flushes
    rx_char(8'h99, 1'b1, 1'b0, 1'b0);
    tx_write(8'h01);
    tick();
    tx_write(8'h02);
    fifo_en_i = 1'b0;
    tick(); tick();
    chk("R12 flushed", {8'h0, lsr_o}, 16'h0060);

    // non-FIFO: capacity 1, R7 off
    rx_char(8'h10, 1'b0, 1'b0, 1'b0);
    rx_char(8'h20, 1'b0, 1'b0, 1'b0);
    chk("R3 R4 single overrun", {6'h0, lsr_o[1:0], rx_data_o}, 16'h0310);
    rx_pop();
    lsr_read();
    chk("R2 single empty", {14'h0, lsr_o[1:0]}, 16'h0);
    rx_char(8'h00, 1'b0, 1'b0, 1'b1);
    chk("R7 off in single mode", {14'h0, lsr_o[7], lsr_o[4]}, 16'h1);
    rx_pop();

    tx_write(8'h31);
    tick();
    tx_write(8'h32);
    tx_write(8'h33);
    chk("R8 single holding full", {15'h0, lsr_o[5]}, 16'h0);
    tx_done();
    chk("R8 R10 kept byte", {7'h0, tx_load_o, tx_load_data_o}, 16'h0132);
    tick();
    chk("R8 extra write dropped", {14'h0, lsr_o[6:5]}, 16'h1);
    tx_done();
    chk("R9 single idle", {8'h0, lsr_o}, 16'h0060);

    summary();
  end
endmodule